// File: doc/BRIEF.md
# Decimal 4221 Carry-Save Adder

This block is a purely combinational 3:2 carry-save adder for decimal operands of `NDIG` digits. Every digit is four bits in the weighted (4,2,2,1) code. It takes three such operands and returns two results. The first is a sum vector. The second is a vector that already holds twice the carry, so the two outputs can be added as they stand. Their combined decimal value equals the sum of the three inputs. The block is a reduction cell for multi-operand decimal addition, for example when partial products are summed in a decimal multiplier.

Each digit position adds its three input digits with an ordinary four-bit binary 3:2 adder. This is valid because the code is weighted bit by bit. The carry digit is then doubled without BCD correction. It is first recoded to the (5,2,1,1) code, and that code is shifted left by one bit. The top bit of each recoded digit crosses into the lowest bit of the next digit up. The doubled-carry output has one more digit than the inputs, so the carry leaving the top digit is kept.

Top module: `dec4221_csa`

## Requirements
- R1: Digit k of every bus occupies bits [4k+3:4k], and its value is 4*b3 + 2*b2 + 2*b1 + b0. All sixteen bit patterns are legal inputs, including the redundant ones.
- R2: The decimal value of `sum_o` plus the decimal value of `dbl_o` equals the sum of the values of `a_i`, `b_i` and `c_i`, for any inputs.
- R3: Each bit of `sum_o` is the parity of the three input bits in the same position. The carry digit H of position k is the bitwise majority of the three input digits.
- R4: For k < NDIG, bits [4k+3:4k+1] of `dbl_o` encode r = H mod 5, where H is the value of the carry digit. The codes are 0→000, 1→010, 2→100, 3→110, 4→111, with the left bit at bit 4k+3.
- R5: For k < NDIG, bit 4(k+1) of `dbl_o` is 1 exactly when the carry digit of position k has a value of 5 or more.
- R6: Bit 0 of `dbl_o` is always 0.
- R7: Bits [4*NDIG+3:4*NDIG+1] of `dbl_o` are always 0. The top digit of `dbl_o` therefore has a value of 0 or 1.
- R8: The outputs depend only on the present inputs and need no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NDIG | First operand, 4221 digits |
| b_i | input | 4*NDIG | Second operand, 4221 digits |
| c_i | input | 4*NDIG | Third operand, 4221 digits |
| sum_o | output | 4*NDIG | Sum vector, 4221 digits |
| dbl_o | output | 4*NDIG+4 | Doubled carry vector, 4221 digits, one digit wider |

## Verification
The bench builds the block at the default NDIG of 4. At this width, three operands with every digit at nine drive a recoded carry through every position and out of the top digit. It also shows digit-to-digit crossing in both directions at once. The exhaustive part feeds each of the 4096 per-digit input triples, rotated differently in each position. In this way every redundant 4221 pattern of every value reaches the binary adder and the recoder, next to neighbours that either set or clear the incoming shifted bit.

// File: rtl/dec4221_csa.sv
module dec4221_csa #(
  parameter int NDIG = 4
) (
  input  logic [4*NDIG-1:0] a_i,
  input  logic [4*NDIG-1:0] b_i,
  input  logic [4*NDIG-1:0] c_i,
  output logic [4*NDIG-1:0] sum_o,
  output logic [4*NDIG+3:0] dbl_o
);
  localparam int TOP = 4*NDIG;

  assign dbl_o[0]           = 1'b0;
  assign dbl_o[TOP+3:TOP+1] = 3'b000;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] da, db, dc, h, hv, w;
    assign da = a_i[4*g +: 4];
    assign db = b_i[4*g +: 4];
    assign dc = c_i[4*g +: 4];

    assign sum_o[4*g +: 4] = da ^ db ^ dc;
    assign h  = (da & db) | (da & dc) | (db & dc);
    assign hv = {h[3], 2'b00} + {2'b00, h[2], 1'b0} + {2'b00, h[1], 1'b0} + {3'b000, h[0]};

    always_comb begin
      case (hv)
        4'd0:    w = 4'b0000;
        4'd1:    w = 4'b0010;
        4'd2:    w = 4'b0100;
        4'd3:    w = 4'b0110;
        4'd4:    w = 4'b0111;
        4'd5:    w = 4'b1000;
        4'd6:    w = 4'b1010;
        4'd7:    w = 4'b1100;
        4'd8:    w = 4'b1110;
        4'd9:    w = 4'b1111;
        default: w = 4'b0000;
      endcase
    end

    assign dbl_o[4*g+1 +: 3] = w[2:0];
    assign dbl_o[4*(g+1)]    = w[3];
  end
endmodule

// File: rtl/dec4221_csa_chk.sv
module dec4221_csa_chk #(
  parameter int NDIG = 4
) (
  input logic [4*NDIG-1:0] a_i,
  input logic [4*NDIG-1:0] b_i,
  input logic [4*NDIG-1:0] c_i,
  input logic [4*NDIG-1:0] sum_o,
  input logic [4*NDIG+3:0] dbl_o
);
  function automatic int dv(input logic [3:0] d);
    return 4*d[3] + 2*d[2] + 2*d[1] + d[0];
  endfunction

  function automatic longint tot(input logic [4*NDIG+3:0] v);
    longint acc = 0;
    longint wt = 1;
    for (int k = 0; k <= NDIG; k++) begin
      acc += wt * dv(v[4*k +: 4]);
      wt  *= 10;
    end
    return acc;
  endfunction

  always_comb begin
    p_total_value_r2: assert (tot({4'b0, a_i}) + tot({4'b0, b_i}) + tot({4'b0, c_i})
                              == tot({4'b0, sum_o}) + tot(dbl_o))
      else $error("total value not kept");
    p_low_zero_r6: assert (dbl_o[0] == 1'b0) else $error("lowest doubled bit set");
    p_top_digit_r7: assert (dbl_o[4*NDIG+3:4*NDIG+1] == 3'b000) else $error("top digit too large");
    for (int k = 0; k < NDIG; k++) begin
      p_digit_balance_r5: assert (dv(a_i[4*k +: 4]) + dv(b_i[4*k +: 4]) + dv(c_i[4*k +: 4])
                                  == dv(sum_o[4*k +: 4]) + 10*dbl_o[4*(k+1)]
                                     + dv(dbl_o[4*k +: 4]) - dbl_o[4*k])
        else $error("digit balance broken");
      p_code_set_r4: assert (dbl_o[4*k+1 +: 3] inside {3'b000, 3'b010, 3'b100, 3'b110, 3'b111})
        else $error("illegal remainder code");
    end
  end
endmodule

bind dec4221_csa dec4221_csa_chk #(.NDIG(NDIG)) u_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .sum_o(sum_o), .dbl_o(dbl_o)
);

// File: tb/dec4221_csa_tb.sv
module dec4221_csa_tb;
  localparam int NDIG = 4;
  localparam int W = 4*NDIG;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [W-1:0] sum;
  logic [W+3:0] dbl;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec4221_csa #(.NDIG(NDIG)) u_dut (.a_i(a), .b_i(b), .c_i(c), .sum_o(sum), .dbl_o(dbl));

  function automatic int dv(input logic [3:0] d);
    return 4*d[3] + 2*d[2] + 2*d[1] + d[0];
  endfunction

  function automatic longint tot(input logic [W+3:0] v);
    longint acc = 0, wt = 1;
    for (int k = 0; k <= NDIG; k++) begin
      acc += wt * dv(v[4*k +: 4]);
      wt  *= 10;
    end
    return acc;
  endfunction

  function automatic logic [2:0] rcode(input int r);
    case (r)
      0: return 3'b000;
      1: return 3'b010;
      2: return 3'b100;
      3: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [W-1:0] xa, xb, xc);
    logic [W-1:0] es;
    logic [W+3:0] ed;
    @(posedge clk);
    a = xa; b = xb; c = xc;
    es = '0; ed = '0;
    for (int k = 0; k < NDIG; k++) begin
      logic [3:0] da, db, dc, h;
      int hv;
      da = xa[4*k +: 4]; db = xb[4*k +: 4]; dc = xc[4*k +: 4];
      for (int j = 0; j < 4; j++) begin
        es[4*k+j] = da[j] ^ db[j] ^ dc[j];
        h[j] = (int'(da[j]) + int'(db[j]) + int'(dc[j])) >= 2;
      end
      hv = dv(h);
      ed[4*k+1 +: 3] = rcode(hv % 5);
      ed[4*(k+1)]    = (hv >= 5);
    end
    @(negedge clk);
    chk("R3 sum parity", 64'(sum), 64'(es));
    chk("R4/R5/R6/R7 doubled carry", 64'(dbl), 64'(ed));
    chk("R2 total value", 64'(tot({4'b0, sum}) + tot(dbl)),
        64'(tot({4'b0, xa}) + tot({4'b0, xb}) + tot({4'b0, xc})));
  endtask

  initial begin
    void'($urandom(32'd20251));
    @(negedge clk);
    chk("R8 zero inputs sum", 64'(sum), 64'd0);
    chk("R6 zero inputs doubled", 64'(dbl), 64'd0);

    // R7: all nines push a carry out of the top digit
    apply_and_check({W{1'b1}}, {W{1'b1}}, {W{1'b1}});
    chk("R7 all nines doubled", 64'(dbl), 64'h1FFFE);
    chk("R1 all nines sum", 64'(sum), 64'hFFFF);

    // R1: every per-digit triple, rotated per digit position
    for (int p = 0; p < 4096; p++) begin
      logic [W-1:0] xa, xb, xc;
      for (int k = 0; k < NDIG; k++) begin
        logic [11:0] t;
        t = 12'((p + k*1237) % 4096);
        xa[4*k +: 4] = t[3:0]; xb[4*k +: 4] = t[7:4]; xc[4*k +: 4] = t[11:8];
      end
      apply_and_check(xa, xb, xc);
    end

    for (int n = 0; n < 3000; n++)
      apply_and_check(W'($urandom), W'($urandom), W'($urandom));

    apply_and_check('0, '0, '0);
    chk("R6 lowest bit after zeros", 64'(dbl[0]), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule